// File: doc/BRIEF.md
# Reloadable Bus-Cycle Interrupt Timer

This block counts CPU bus cycles down from a programmed value and raises an interrupt request when the count runs out. Software writes a 16-bit reload value one byte at a time into a holding latch. A separate control write then starts or stops counting. The same control write moves the latch into the live counter and withdraws any pending request. Latch writes never change the running count, so software can stage the next period while the current one is still in progress.

The block sits behind an address decoder that has already reduced the CPU address to a 4-bit register offset. It receives a write strobe, the offset, the data byte and a one-cycle pulse per CPU bus cycle (`m2_tick`). It drives a level interrupt request, which the CPU interrupt logic samples. The counter stops at zero and does not wrap, so the request stays asserted until software reloads the counter.

Top module: `irq_cycle_timer`

## Requirements
- R1: The reload latch is 16 bits. A write at offset 0xB sets its low byte and a write at offset 0xC sets its high byte. A reload value N makes the request appear N bus-cycle pulses after the load.
- R2: Latch writes leave the running counter untouched, including writes made while counting is in progress.
- R3: A write at offset 0xA sets the count enable from data bit 0 (1 = run, 0 = stop). Data bits 7..1 of that write are ignored.
- R4: Every write at offset 0xA copies the latch into the counter and clears a pending request on the same clock edge.
- R5: While enabled, the counter decreases by one on each clock where `m2_tick` is high. It does not change on clocks without a pulse or while disabled.
- R6: While enabled, `irq` goes high on the clock edge at which the counter reaches zero.
- R7: A control write that sets the enable while the latch value being loaded is zero raises `irq` on that same edge.
- R8: Once high, `irq` stays high until the next control write or reset. The counter holds at zero and does not wrap.
- R9: A synchronous active-high reset clears the counter, the latch, the enable and `irq` to zero.
- R10: Writes at offsets other than 0xA, 0xB and 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Register write strobe, one clock per write |
| wr_ofs | input | 4 | Decoded register offset |
| wr_data | input | 8 | Write data byte |
| m2_tick | input | 1 | One-clock pulse per CPU bus cycle |
| irq | output | 1 | Interrupt request level, active high |

## Verification
The counter is run with a pulse on every clock, with a pulse on every third clock, and with random pulse density. The first pattern checks the raw N-pulse timing. The sparse patterns show that the count advances on pulses and not on clocks. Reload values of 5, 80, 258 and 0 check the byte order, the high-byte carry path and the immediate zero-load case. Latch writes during a running count, writes to unused offsets and control writes with bits other than bit 0 set show which writes change the timing and which do not. A random stretch that mixes writes and pulses is compared every clock against a behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned OFS_W = 4;
    typedef logic [OFS_W-1:0] ofs_t;

    localparam ofs_t OFS_CTRL       = 4'hA;
    localparam ofs_t OFS_LATCH_BASE = 4'hB;

    typedef struct packed {
        logic load;     // control register written this cycle
        logic run;      // enable value carried by that write
    } ctrl_cmd_t;

    function automatic ofs_t latch_ofs(input int unsigned idx);
        return ofs_t'(int'(OFS_LATCH_BASE) + int'(idx));
    endfunction
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  ofs_t              wr_ofs,
    input  logic              run_bit,
    output ctrl_cmd_t         cmd,
    output logic [NBYTES-1:0] latch_we,
    output logic              en_q
);
    always_comb begin
        cmd.load = wr_stb && (wr_ofs == OFS_CTRL);
        cmd.run  = run_bit;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_we
        assign latch_we[b] = wr_stb && (wr_ofs == latch_ofs(b));
    end

    always_ff @(posedge clk) begin
        if (rst)           en_q <= 1'b0;
        else if (cmd.load) en_q <= run_bit;
    end

    // R10: a single write targets at most one register
    a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.load, latch_we}));

    // R3: enable follows bit 0 of the control write
    a_r3_enable_follows: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (en_q == $past(run_bit)));

    // R3: enable is unchanged without a control write
    a_r3_enable_stable: assert property (@(posedge clk) disable iff (rst)
        !cmd.load |=> $stable(en_q));
endmodule

// File: rtl/irqc_latch.sv
module irqc_latch #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NBYTES = 2,
    localparam int unsigned CNT_W = DATA_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NBYTES-1:0] latch_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  latch_val
);
    logic [DATA_W-1:0] byte_q [NBYTES];

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)              byte_q[b] <= '0;
            else if (latch_we[b]) byte_q[b] <= wr_data;
        end
        assign latch_val[b*DATA_W +: DATA_W] = byte_q[b];

        // R1: a byte write lands in its own slice, little-endian
        a_r1_byte_lands: assert property (@(posedge clk) disable iff (rst)
            latch_we[b] |=> (latch_val[b*DATA_W +: DATA_W] == $past(wr_data)));
    end

    // R1: the latch is unchanged without a byte write
    a_r1_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (latch_we == '0) |=> $stable(latch_val));
endmodule

// File: rtl/irqc_counter.sv
module irqc_counter
    import irqc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_cmd_t        cmd,
    input  logic             en_q,
    input  logic             m2_tick,
    input  logic [CNT_W-1:0] latch_val,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             irq_d;
    logic             cnt_zero, step;

    assign cnt_zero = (cnt_q == '0);
    assign step     = en_q && m2_tick && !cnt_zero;

    always_comb begin
        cnt_d = cnt_q;
        irq_d = irq;
        if (cmd.load) begin
            cnt_d = latch_val;
            irq_d = cmd.run && (latch_val == '0);
        end else begin
            if (step) cnt_d = cnt_q - 1'b1;
            if (en_q && (cnt_d == '0)) irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq   <= irq_d;
        end
    end

    // R4: control write loads the latch
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (cnt_q == $past(latch_val)));

    // R2 / R5: no load and no pulse while enabled leaves the count alone
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && !(en_q && m2_tick)) |=> $stable(cnt_q));

    // R5: an enabled pulse decrements a non-zero count by one
    a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && en_q && m2_tick && !cnt_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8: no wrap below zero
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && cnt_zero) |=> (cnt_q == '0));

    // R8: request is sticky until a control write
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !cmd.load) |=> irq);

    // R6: enabled at zero means a raised request
    a_r6_zero_raises: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && en_q && cnt_zero) |=> irq);

    // R4: a stopping control write leaves the request low
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd.load && !cmd.run) |=> !irq);

    // R7: enabling with a zero latch fires on that edge
    a_r7_immediate: assert property (@(posedge clk) disable iff (rst)
        (cmd.load && cmd.run && (latch_val == '0)) |=> irq);
endmodule

// File: rtl/irq_cycle_timer.sv
module irq_cycle_timer
    import irqc_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NBYTES = 2,
    localparam int unsigned CNT_W = DATA_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              m2_tick,
    output logic              irq
);
    ctrl_cmd_t         cmd;
    logic [NBYTES-1:0] latch_we;
    logic              en_q;
    logic [CNT_W-1:0]  latch_val;

    irqc_ctrl #(.NBYTES(NBYTES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_ofs   (wr_ofs),
        .run_bit  (wr_data[0]),
        .cmd      (cmd),
        .latch_we (latch_we),
        .en_q     (en_q)
    );

    irqc_latch #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .latch_we  (latch_we),
        .wr_data   (wr_data),
        .latch_val (latch_val)
    );

    irqc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .en_q      (en_q),
        .m2_tick   (m2_tick),
        .latch_val (latch_val),
        .irq       (irq)
    );

    // R9: reset leaves the request low
    a_r9_reset_low: assert property (@(posedge clk)
        rst |=> !irq);
endmodule

// File: tb/irq_cycle_timer_tb.sv
module irq_cycle_timer_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_stb = 1'b0;
    logic [3:0] wr_ofs = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic m2_tick = 1'b0;
    logic irq;

    always #10 clk = ~clk;   // 50 MHz

    irq_cycle_timer dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .m2_tick(m2_tick), .irq(irq)
    );

    int vectors = 0;
    int miscompares = 0;
    string tag = "R9";
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference
    int m_cnt = 0;
    int m_latch = 0;
    bit m_en = 0;
    bit m_irq = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_latch = 0; m_en = 0; m_irq = 0;
        end else if (wr_stb && wr_ofs == 4'hA) begin
            m_en  = wr_data[0];
            m_cnt = m_latch;
            m_irq = wr_data[0] && (m_latch == 0);
        end else begin
            if (wr_stb && wr_ofs == 4'hB) m_latch = (m_latch & 16'hFF00) | int'(wr_data);
            if (wr_stb && wr_ofs == 4'hC) m_latch = (m_latch & 16'h00FF) | (int'(wr_data) << 8);
            if (m_en) begin
                if (m2_tick && m_cnt > 0) m_cnt = m_cnt - 1;
                if (m_cnt == 0) m_irq = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            vectors++;
            if (irq !== m_irq) begin
                miscompares++;
                $display("FAIL %s: model compare irq=%0b expected %0b at %0t", tag, irq, m_irq, $time);
            end
        end
    end

    task automatic cyc(input logic w, input logic [3:0] o, input logic [7:0] d, input logic t);
        @(negedge clk);
        rst = 1'b0; wr_stb = w; wr_ofs = o; wr_data = d; m2_tick = t;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n, input logic t);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 8'h00, t);
    endtask

    task automatic wreg(input logic [3:0] o, input logic [7:0] d);
        cyc(1'b1, o, d, 1'b0);
    endtask

    task automatic expect_irq(input logic exp, input string req);
        vectors++;
        if (irq !== exp) begin
            miscompares++;
            $display("FAIL %s: irq=%0b expected %0b at %0t", req, irq, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R5: watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        cmp_on = 1'b1;
        tag = "R9";
        expect_irq(1'b0, "R9 after reset");

        // basic count of 5
        tag = "R6";
        wreg(4'hB, 8'h05); wreg(4'hC, 8'h00); wreg(4'hA, 8'h01);
        expect_irq(1'b0, "R4 after load of 5");
        idle(4, 1'b1); expect_irq(1'b0, "R6 one pulse early");
        idle(1, 1'b1); expect_irq(1'b1, "R6 fifth pulse");
        tag = "R8";
        idle(20, 1'b1); expect_irq(1'b1, "R8 sticky");

        // sparse pulses, every third clock
        tag = "R5";
        wreg(4'hB, 8'h03); wreg(4'hA, 8'h01);
        expect_irq(1'b0, "R4 clears on reload");
        for (int i = 1; i <= 8; i++) cyc(1'b0, 4'h0, 8'h00, (i % 3) == 0);
        expect_irq(1'b0, "R5 two pulses seen");
        idle(1, 1'b1); expect_irq(1'b1, "R5 third pulse");

        // latch writes during a running count
        tag = "R2";
        wreg(4'hB, 8'h06); wreg(4'hA, 8'h01);
        idle(2, 1'b1);
        cyc(1'b1, 4'hB, 8'h50, 1'b1);
        cyc(1'b1, 4'hC, 8'h00, 1'b1);
        idle(1, 1'b1); expect_irq(1'b0, "R2 five pulses of six");
        idle(1, 1'b1); expect_irq(1'b1, "R2 sixth pulse");

        // ignored offsets, then reload of 80
        tag = "R10";
        for (int o = 0; o < 16; o++)
            if (o < 10 || o > 12) wreg(4'(o), 8'h00);
        expect_irq(1'b1, "R10 stray writes keep irq");
        wreg(4'hA, 8'h01);
        expect_irq(1'b0, "R10 latch kept 80");
        idle(79, 1'b1); expect_irq(1'b0, "R10 79 pulses");
        idle(1, 1'b1); expect_irq(1'b1, "R10 80th pulse");

        // stop via bit 0 clear, other bits set
        tag = "R3";
        wreg(4'hA, 8'hFE);
        expect_irq(1'b0, "R3 stop clears");
        idle(100, 1'b1); expect_irq(1'b0, "R3 stopped stays low");

        // high byte path: 0x0102 = 258, enable with extra bits set
        tag = "R1";
        wreg(4'hB, 8'h02); wreg(4'hC, 8'h01); wreg(4'hA, 8'h03);
        idle(257, 1'b1); expect_irq(1'b0, "R1 257 pulses");
        idle(1, 1'b1); expect_irq(1'b1, "R1 258th pulse");
        wreg(4'hA, 8'h00);
        expect_irq(1'b0, "R4 disable write clears");

        // zero latch fires at once
        tag = "R7";
        wreg(4'hB, 8'h00); wreg(4'hC, 8'h00); wreg(4'hA, 8'h01);
        expect_irq(1'b1, "R7 immediate");
        wreg(4'hA, 8'h00);
        expect_irq(1'b0, "R7 stop with zero latch");

        // reset mid-count
        tag = "R9";
        wreg(4'hB, 8'h0A); wreg(4'hA, 8'h01); idle(3, 1'b1);
        @(negedge clk); rst = 1'b1; wr_stb = 1'b0; m2_tick = 1'b1;
        @(posedge clk); #1;
        expect_irq(1'b0, "R9 reset low");
        wreg(4'hA, 8'h01);
        expect_irq(1'b1, "R9 latch cleared by reset");

        // random mix
        tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 99));
            logic t = ($urandom_range(0, 3) != 0);
            if (r < 3)       cyc(1'b1, 4'hA, 8'($urandom), t);
            else if (r < 6)  cyc(1'b1, 4'hB, 8'($urandom_range(0, 40)), t);
            else if (r < 8)  cyc(1'b1, 4'hC, 8'($urandom_range(0, 1) == 0 ? 0 : 1), t);
            else if (r < 10) cyc(1'b1, 4'($urandom), 8'($urandom), t);
            else             cyc(1'b0, 4'h0, 8'h00, t);
        end

        finish_run();
    end
endmodule